// File: doc/BRIEF.md
# Dual Byte FIFO with Trigger Flags

This block buffers bytes between a register-mapped data port and a serial bus engine. It holds two independent byte queues. The transmit queue is filled by register writes and drained by the engine. The receive queue is filled by the engine and drained by register reads. Software can read each queue's fill level directly.

Each queue has a programmable trigger. The receive trigger fires once a chosen number of bytes (1 to 16) has arrived. The transmit trigger fires when the queue has drained to one of four coded low-water levels. A third flag records that the engine has finished the final byte, including its acknowledge slot, and that no data remains queued. The three flags are sticky until software clears them by writing 0 to them. Each flag has its own interrupt enable. A control bit for each queue holds that queue empty for as long as the bit is set.

The register port uses a 3-bit select:

| Select | Register |
|---|---|
| 0 | control |
| 1 | status |
| 2 | interrupt enable |
| 3 | receive count |
| 4 | transmit count |
| 5 | data |

Selects 6 and 7 read as 0.

Top module: `dual_byte_fifo`

## Requirements
- R1: Each queue holds 16 bytes. Select 3 reads the receive fill count and select 4 reads the transmit fill count, each from 0 to 16. After reset, both counts are 0, control and interrupt enable read 0, status reads 0x01, and irq is low.
- R2: A register write to select 5 appends a byte to the transmit queue. `tx_head` shows the oldest byte, and a `tx_pop` removes it, so bytes leave in write order.
- R3: A write to select 5 while the transmit queue holds 16 bytes is ignored. The count stays 16 and the stored bytes are unchanged.
- R4: `rx_push` stores `rx_byte` in the receive queue, and a register read of select 5 returns and removes the oldest byte. A read of the empty queue returns 0 and leaves the count at 0.
- R5: While control bit 0 is 1, the transmit queue is held empty and data writes are dropped. While control bit 1 is 1, the receive queue is held empty and `rx_push` is dropped.
- R6: Control bits [7:4] hold a receive trigger value N. Status bit 1 is set while the receive count is at least N+1.
- R7: Control bits [3:2] select a transmit low-water level: code 0 is 8 bytes, code 1 is 4, code 2 is 2 and code 3 is 0. Status bit 0 is set while the transmit count is at or below the selected level.
- R8: Status bit 2 is set when `tx_byte_done` is high while the transmit queue is empty. It is not set when the pulse arrives with bytes still queued.
- R9: Status bits are sticky. A write to select 1 clears each bit written as 0 and keeps each bit written as 1. A bit whose condition is still true reads 1 regardless of the write.
- R10: Select 2 holds the interrupt enables: bit 0 for the transmit trigger, bit 1 for the receive trigger and bit 2 for transmit-end. `irq` is high when any status bit and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of select 5 pops the receive queue |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_pop | input | 1 | Engine takes the oldest transmit byte |
| tx_head | output | 8 | Oldest transmit byte, 0 when the queue is empty |
| tx_byte_done | input | 1 | Engine finished a byte including its acknowledge slot |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |

## Verification
The queues are exercised with short ordered bursts, with a burst that overruns the transmit queue, and with reads of an empty receive queue. Together these separate correct ordering from lost or duplicated entries and from broken bounds. Each transmit trigger code is tested just above and just at its level, which exposes any error in the code-to-level mapping. The receive trigger is tested at N+1 minus one byte and at N+1, which exposes an off-by-one. The transmit-end pulse is applied once with a byte still queued and once with the queue empty, and status writes that clear a bit are contrasted with writes that keep it.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_IEN   = 3'd2,
        SEL_RXCNT = 3'd3,
        SEL_TXCNT = 3'd4,
        SEL_DATA  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic [3:0] rx_thresh;
        logic [1:0] tx_code;
        logic       rx_hold;
        logic       tx_hold;
    } ctrl_t;

    typedef struct packed {
        logic tx_end;
        logic rx_ready;
        logic tx_low;
    } flags_t;

    function automatic int unsigned tx_level(input logic [1:0] code);
        case (code)
            2'd0:    return 8;
            2'd1:    return 4;
            2'd2:    return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/dbf_byte_fifo.sv
module dbf_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          is_full, is_empty, do_push, do_pop;

    assign is_full  = (count == CW'(DEPTH));
    assign is_empty = (count == '0);
    assign do_push  = push && !flush && !is_full;
    assign do_pop   = pop && !flush && !is_empty;
    assign rdata    = is_empty ? '0 : mem[rd_ptr];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    p_count_limit_r1: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    p_full_push_r3: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && count == CW'(DEPTH)) |=> count == CW'(DEPTH));
    p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !flush && count == '0) |=> count == '0);
    p_flush_r5: assert property (@(posedge clk) disable iff (rst)
        flush |=> count == '0);

endmodule

// File: rtl/dbf_flag_unit.sv
module dbf_flag_unit
    import dbf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctrl,
    input  logic [CW-1:0] tx_cnt,
    input  logic [CW-1:0] rx_cnt,
    input  logic          tx_byte_done,
    input  logic          stat_wr,
    input  flags_t        stat_wdata,
    output flags_t        stat
);
    flags_t cond, keep, held;

    always_comb begin
        cond.tx_low   = (int'(tx_cnt) <= tx_level(ctrl.tx_code));
        cond.rx_ready = (rx_cnt >= (CW'(ctrl.rx_thresh) + CW'(1)));
        cond.tx_end   = tx_byte_done && (tx_cnt == '0);
        keep          = stat_wr ? stat_wdata : '1;
    end

    always_ff @(posedge clk) begin
        if (rst) held <= '0;
        else     held <= (held & keep) | cond;
    end

    assign stat = held | cond;

    p_txend_needs_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (!held.tx_end && tx_byte_done && tx_cnt != '0) |-> !stat.tx_end);
    p_txend_cleared_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !stat_wdata.tx_end && !tx_byte_done) |=> !held.tx_end);
    p_rx_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt > CW'(ctrl.rx_thresh)) |-> stat.rx_ready);

endmodule

// File: rtl/dual_byte_fifo.sv
module dual_byte_fifo
    import dbf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [2:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_head,
    input  logic          tx_byte_done,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_byte,
    output logic          irq
);
    ctrl_t         ctrl_q;
    flags_t        ien_q, stat;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [DW-1:0] rx_head;
    logic          data_wr, data_rd;

    assign data_wr = reg_wr && (reg_sel == SEL_DATA);
    assign data_rd = reg_rd && (reg_sel == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ien_q  <= '0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_CTRL) ctrl_q <= ctrl_t'(reg_wdata[7:0]);
            if (reg_sel == SEL_IEN)  ien_q  <= flags_t'(reg_wdata[2:0]);
        end
    end

    dbf_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst(rst), .flush(ctrl_q.tx_hold),
        .push(data_wr), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt)
    );

    dbf_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst(rst), .flush(ctrl_q.rx_hold),
        .push(rx_push), .wdata(rx_byte),
        .pop(data_rd), .rdata(rx_head), .count(rx_cnt)
    );

    dbf_flag_unit #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst(rst), .ctrl(ctrl_q),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .tx_byte_done(tx_byte_done),
        .stat_wr(reg_wr && (reg_sel == SEL_STAT)),
        .stat_wdata(flags_t'(reg_wdata[2:0])),
        .stat(stat)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CTRL:  reg_rdata = DW'(ctrl_q);
            SEL_STAT:  reg_rdata = DW'(stat);
            SEL_IEN:   reg_rdata = DW'(ien_q);
            SEL_RXCNT: reg_rdata = DW'(rx_cnt);
            SEL_TXCNT: reg_rdata = DW'(tx_cnt);
            SEL_DATA:  reg_rdata = rx_head;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(stat & ien_q);

    p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq);
    p_tx_write_dropped_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.tx_hold && !(reg_wr && reg_sel == SEL_CTRL)) |=> tx_cnt == '0);

endmodule

// File: tb/dual_byte_fifo_tb_top.sv
module dual_byte_fifo_tb_top;
    logic       clk = 0;
    logic       rst = 1;
    logic       reg_wr = 0, reg_rd = 0;
    logic [2:0] reg_sel = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       tx_pop = 0;
    logic [7:0] tx_head;
    logic       tx_byte_done = 0;
    logic       rx_push = 0;
    logic [7:0] rx_byte = 0;
    logic       irq;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_byte_fifo dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_head(tx_head), .tx_byte_done(tx_byte_done),
        .rx_push(rx_push), .rx_byte(rx_byte), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_sel = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_sel = a; reg_rd = 1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic eng_push(input logic [7:0] d);
        @(negedge clk);
        rx_byte = d; rx_push = 1;
        @(negedge clk);
        rx_push = 0;
    endtask

    task automatic eng_pop(output logic [7:0] d);
        @(negedge clk);
        d = tx_head; tx_pop = 1;
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        tx_byte_done = 1;
        @(negedge clk);
        tx_byte_done = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd_reg(3'd3, v); check(v == 0, "R1 rx count after reset", v, 0);
        rd_reg(3'd4, v); check(v == 0, "R1 tx count after reset", v, 0);
        rd_reg(3'd0, v); check(v == 0, "R1 ctrl after reset", v, 0);
        rd_reg(3'd2, v); check(v == 0, "R1 ien after reset", v, 0);
        rd_reg(3'd1, v); check(v == 8'h01, "R1 status after reset", v, 1);
        check(irq == 0, "R1 irq after reset", irq, 0);
    endtask

    task automatic t_tx_overrun();
        logic [7:0] v;
        for (int i = 0; i < 17; i++) wr_reg(3'd5, 8'hA0 + 8'(i));
        rd_reg(3'd4, v); check(v == 16, "R3 tx count after overrun", v, 16);
        for (int i = 0; i < 16; i++) begin
            eng_pop(v);
            check(v == 8'hA0 + 8'(i), "R2 tx order", v, 8'hA0 + i);
        end
        rd_reg(3'd4, v); check(v == 0, "R3 tx count after drain", v, 0);
        check(tx_head == 0, "R2 empty head", tx_head, 0);
    endtask

    task automatic t_rx_order();
        logic [7:0] v;
        eng_push(8'h11); eng_push(8'h22); eng_push(8'h33);
        rd_reg(3'd3, v); check(v == 3, "R1 rx count", v, 3);
        rd_reg(3'd5, v); check(v == 8'h11, "R4 rx first", v, 8'h11);
        rd_reg(3'd5, v); check(v == 8'h22, "R4 rx second", v, 8'h22);
        rd_reg(3'd5, v); check(v == 8'h33, "R4 rx third", v, 8'h33);
        rd_reg(3'd5, v); check(v == 0, "R4 read empty data", v, 0);
        rd_reg(3'd3, v); check(v == 0, "R4 count after empty read", v, 0);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        for (int i = 0; i < 5; i++) wr_reg(3'd5, 8'(i));
        eng_push(8'h55);
        wr_reg(3'd0, 8'h01);
        rd_reg(3'd4, v); check(v == 0, "R5 tx held empty", v, 0);
        wr_reg(3'd5, 8'h77);
        rd_reg(3'd4, v); check(v == 0, "R5 tx write dropped", v, 0);
        rd_reg(3'd3, v); check(v == 1, "R5 rx untouched by tx hold", v, 1);
        wr_reg(3'd0, 8'h02);
        eng_push(8'h66);
        rd_reg(3'd3, v); check(v == 0, "R5 rx held empty", v, 0);
        wr_reg(3'd0, 8'h00);
    endtask

    task automatic t_rx_trigger();
        logic [7:0] v;
        wr_reg(3'd0, 8'h30);
        wr_reg(3'd1, 8'h00);
        for (int i = 0; i < 3; i++) eng_push(8'(i));
        rd_reg(3'd1, v); check(v[1] == 0, "R6 rx flag below N+1", v[1], 0);
        eng_push(8'h03);
        rd_reg(3'd1, v); check(v[1] == 1, "R6 rx flag at N+1", v[1], 1);
        wr_reg(3'd0, 8'h02);
        wr_reg(3'd0, 8'h00);
        wr_reg(3'd1, 8'h00);
    endtask

    task automatic t_tx_trigger(input logic [1:0] code, input int lvl);
        logic [7:0] v;
        wr_reg(3'd0, {4'd0, code, 2'b01});
        wr_reg(3'd0, {4'd0, code, 2'b00});
        for (int i = 0; i <= lvl; i++) wr_reg(3'd5, 8'(i));
        wr_reg(3'd1, 8'h00);
        rd_reg(3'd1, v); check(v[0] == 0, "R7 tx flag above level", v[0], 0);
        eng_pop(v);
        rd_reg(3'd1, v); check(v[0] == 1, "R7 tx flag at level", v[0], 1);
        wr_reg(3'd0, 8'h01);
        wr_reg(3'd0, 8'h00);
    endtask

    task automatic t_tx_end();
        logic [7:0] v;
        wr_reg(3'd5, 8'h9C);
        wr_reg(3'd1, 8'h00);
        pulse_done();
        rd_reg(3'd1, v); check(v[2] == 0, "R8 no end with byte queued", v[2], 0);
        eng_pop(v);
        pulse_done();
        rd_reg(3'd1, v); check(v[2] == 1, "R8 end when empty", v[2], 1);
        wr_reg(3'd1, 8'h04);
        rd_reg(3'd1, v); check(v[2] == 1, "R9 write 1 keeps bit", v[2], 1);
        wr_reg(3'd2, 8'h04);
        #1 check(irq == 1, "R10 irq from tx end", irq, 1);
        wr_reg(3'd2, 8'h02);
        #1 check(irq == 0, "R10 irq masked", irq, 0);
        wr_reg(3'd1, 8'h00);
        rd_reg(3'd1, v); check(v[2] == 0, "R9 write 0 clears bit", v[2], 0);
        check(v[0] == 1, "R9 live condition survives clear", v[0], 1);
        wr_reg(3'd2, 8'h01);
        #1 check(irq == 1, "R10 irq from tx low", irq, 1);
        wr_reg(3'd2, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_tx_overrun();
        t_rx_order();
        t_hold();
        t_rx_trigger();
        t_tx_trigger(2'd0, 8);
        t_tx_trigger(2'd1, 4);
        t_tx_trigger(2'd2, 2);
        t_tx_trigger(2'd3, 0);
        t_tx_end();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule